// File: doc/BRIEF.md
# Serial SRAM Target

This block is the device side of a byte-organized static RAM reached over a four-wire SPI port, plus an active-low pause input. The serial clock, select, data-in and pause lines are brought into a fast system clock through synchronizers. Serial clock edges are detected there. Each command begins with an 8-bit opcode. Memory commands then take a 16-bit address. Bytes are then shifted into or out of an internal array of 2^ADDR_W bytes.

An 8-bit status register holds two settings. The first is the access mode: single byte, wrap inside a page, or run across the whole array. The second enables or disables the pause input. Serial data out is presented as a data bit with a separate output enable, so that the pad level decides when to float the line.

Top module: `spi_sram_target`

## Requirements
- R1: After reset, and whenever the select input (cs_n) is high, so_oe is 0.
- R2: Opcode 0x03 reads and opcode 0x02 writes. Each is followed by a 16-bit address, MSB first. Only the low ADDR_W address bits are used, and the upper bits are ignored.
- R3: Every opcode, address and data bit travels MSB first. si is captured on a rising sck edge, and so_data changes only after a falling sck edge.
- R4: In word mode (status[7:6] = 00, the reset value) and in the reserved mode 11, a read or write moves exactly one byte. Further clocks neither store data nor enable so_oe until cs_n rises.
- R5: In page mode (status[7:6] = 10), the address advances by one after each byte. The low PAGE_W bits wrap from all-ones to zero, and the bits above them never change.
- R6: In burst mode (status[7:6] = 01), the address advances by one after each byte across the whole array. It wraps from the top address to 0.
- R7: Opcode 0x05 returns the 8 status bits, MSB first, over the next 8 clocks. Opcode 0x01 loads the next 8 bits into status. Bits 7:6 and bit 0 are kept, and bits 5:1 always read 0.
- R8: Raising cs_n abandons any command. A write byte that has not received all 8 bits is discarded. The next command is recognized from the first rising sck edge after cs_n falls.
- R9: With the pause enabled (status[0] = 0), taking hold_n low while sck is low pauses at once. While paused, so_oe is 0 and sck and si are ignored. Raising hold_n while sck is low resumes at the same bit.
- R10: If hold_n falls while sck is high, the next falling sck edge is still acted on, and the pause starts after it.
- R11: With status[0] = 1, hold_n has no effect on transfers or on so_oe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than sck |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Active-low pause request |
| so_data | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for so_data |

## Verification
The bench builds the block with ADDR_W = 8 and PAGE_W = 3, giving a 256-byte array of 8-byte pages. At this size a write of four bytes already crosses a page boundary, and an address near 0xFF reaches the burst wrap within one short transaction. Addresses sent with the upper byte set confirm that the bits above ADDR_W are ignored. Serial clock half-periods of eight system clocks leave room for the synchronizer latency. This margin lets the bench place hold_n transitions on either level of sck.

// File: rtl/spi_sram_pkg.sv
package spi_sram_pkg;

   localparam logic [7:0] OPC_READ  = 8'h03;
   localparam logic [7:0] OPC_WRITE = 8'h02;
   localparam logic [7:0] OPC_RSTAT = 8'h05;
   localparam logic [7:0] OPC_WSTAT = 8'h01;

   localparam int CMD_ADDR_BITS = 16;

   typedef enum logic [1:0] {
      AM_WORD  = 2'b00,
      AM_BURST = 2'b01,
      AM_PAGE  = 2'b10,
      AM_RSVD  = 2'b11
   } amode_t;

   typedef enum logic [2:0] {
      PH_CMD,
      PH_ADDR,
      PH_WR,
      PH_RD,
      PH_SWR,
      PH_SRD,
      PH_DONE
   } phase_t;

endpackage

// File: rtl/spi_sram_sync.sv
module spi_sram_sync #(
   parameter int             WIDTH     = 4,
   parameter int             STAGES    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("spi_sram_sync: STAGES must be at least 2");
      end
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RESET_VAL;
            else if (g == 0) chain[g] <= d;
            else chain[g] <= chain[(g == 0) ? 0 : g-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_sram_step.sv
module spi_sram_step
   import spi_sram_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int PAGE_W = 5
) (
   input  logic [ADDR_W-1:0] cur,
   input  amode_t            mode,
   output logic [ADDR_W-1:0] nxt
);

   localparam int HI_W = ADDR_W - PAGE_W;

   generate
      if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad
         $error("spi_sram_step: PAGE_W must lie in 1..ADDR_W-1");
      end
   endgenerate

   logic [PAGE_W-1:0] low_inc;
   logic [HI_W-1:0]   high_keep;

   assign low_inc   = cur[PAGE_W-1:0] + 1'b1;
   assign high_keep = cur[ADDR_W-1:PAGE_W];

   always_comb begin
      if (mode == AM_PAGE) nxt = {high_keep, low_inc};
      else                 nxt = cur + 1'b1;
   end

endmodule

// File: rtl/spi_sram_array.sv
module spi_sram_array #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [7:0]        wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [7:0]        rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/spi_sram_target.sv
module spi_sram_target
   import spi_sram_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int PAGE_W      = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic si,
   input  logic hold_n,
   output logic so_data,
   output logic so_oe
);

   localparam int ACNT_W = $clog2(CMD_ADDR_BITS);
   localparam logic [ACNT_W-1:0] ACNT_LAST = ACNT_W'(CMD_ADDR_BITS - 1);

   generate
      if (ADDR_W < 2 || ADDR_W > 15) begin : g_bad_addr
         $error("spi_sram_target: ADDR_W must lie in 2..15");
      end
   endgenerate

   // synchronized inputs: {sck, cs_n, si, hold_n}
   logic [3:0] sync_q;
   logic s_sck, s_cs, s_si, s_hold;

   spi_sram_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RESET_VAL(4'b0101)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({sck, cs_n, si, hold_n}),
      .q    (sync_q)
   );
   assign {s_sck, s_cs, s_si, s_hold} = sync_q;

   logic              sck_q, held, so_en, so_bit, is_rd;
   phase_t            phase;
   logic [2:0]        bitcnt;
   logic [ACNT_W-1:0] acnt;
   logic [6:0]        sh;
   logic [ADDR_W-1:0] addr, addr_nxt;
   logic [7:0]        status, mem_rdata, rd_src, byte_in;

   amode_t mode;
   logic   word_like, hold_low, pause, rise, fall, last_bit, mem_we;

   assign mode      = amode_t'(status[7:6]);
   assign word_like = (mode == AM_WORD) || (mode == AM_RSVD);
   assign hold_low  = ~status[0] & ~s_hold;
   // a pending pause (hold fell with sck high) lets the falling edge through
   assign pause     = held | (hold_low & ~s_sck & ~sck_q);
   assign rise      = s_sck & ~sck_q & ~s_cs & ~pause;
   assign fall      = ~s_sck & sck_q & ~s_cs & ~pause;
   assign last_bit  = (bitcnt == 3'd7);
   assign byte_in   = {sh, s_si};
   assign rd_src    = (phase == PH_SRD) ? status : mem_rdata;
   assign mem_we    = rise && (phase == PH_WR) && last_bit;

   spi_sram_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_step (
      .cur (addr),
      .mode(mode),
      .nxt (addr_nxt)
   );

   spi_sram_array #(.ADDR_W(ADDR_W)) u_array (
      .clk  (clk),
      .we   (mem_we),
      .waddr(addr),
      .wdata(byte_in),
      .raddr(addr),
      .rdata(mem_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q  <= 1'b0;
         held   <= 1'b0;
         so_en  <= 1'b0;
         so_bit <= 1'b0;
         is_rd  <= 1'b0;
         phase  <= PH_CMD;
         bitcnt <= '0;
         acnt   <= '0;
         sh     <= '0;
         addr   <= '0;
         status <= '0;
      end else begin
         sck_q <= s_sck;
         if (s_cs) begin
            phase  <= PH_CMD;
            bitcnt <= '0;
            acnt   <= '0;
            so_en  <= 1'b0;
            held   <= 1'b0;
         end else begin
            if (!s_sck) held <= hold_low;
            if (rise) begin
               case (phase)
                  PH_CMD: begin
                     sh     <= byte_in[6:0];
                     bitcnt <= bitcnt + 3'd1;
                     if (last_bit) begin
                        unique case (byte_in)
                           OPC_READ:  begin phase <= PH_ADDR; is_rd <= 1'b1; end
                           OPC_WRITE: begin phase <= PH_ADDR; is_rd <= 1'b0; end
                           OPC_RSTAT: phase <= PH_SRD;
                           OPC_WSTAT: phase <= PH_SWR;
                           default:   phase <= PH_DONE;
                        endcase
                     end
                  end
                  PH_ADDR: begin
                     addr <= {addr[ADDR_W-2:0], s_si};
                     acnt <= acnt + 1'b1;
                     if (acnt == ACNT_LAST) phase <= is_rd ? PH_RD : PH_WR;
                  end
                  PH_WR: begin
                     sh     <= byte_in[6:0];
                     bitcnt <= bitcnt + 3'd1;
                     if (last_bit) begin
                        addr <= addr_nxt;
                        if (word_like) phase <= PH_DONE;
                     end
                  end
                  PH_SWR: begin
                     sh     <= byte_in[6:0];
                     bitcnt <= bitcnt + 3'd1;
                     if (last_bit) begin
                        status <= {byte_in[7:6], 5'b0, byte_in[0]};
                        phase  <= PH_DONE;
                     end
                  end
                  default: ;
               endcase
            end
            if (fall) begin
               case (phase)
                  PH_RD, PH_SRD: begin
                     so_bit <= rd_src[~bitcnt];
                     so_en  <= 1'b1;
                     bitcnt <= bitcnt + 3'd1;
                     if (last_bit) begin
                        if (phase == PH_SRD) phase <= PH_DONE;
                        else begin
                           addr <= addr_nxt;
                           if (word_like) phase <= PH_DONE;
                        end
                     end
                  end
                  PH_DONE: so_en <= 1'b0;
                  default: ;
               endcase
            end
         end
      end
   end

   assign so_data = so_bit;
   assign so_oe   = so_en & ~s_cs & ~hold_low & ~held;

   AST_ABANDON_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      s_cs |=> (phase == PH_CMD && bitcnt == 3'd0)) else $error("abandon"); // R8
   AST_WORD_SINGLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && word_like) |=> (phase == PH_DONE)) else $error("word"); // R4
   AST_PAGE_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mode == AM_PAGE) |=> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])) else $error("page"); // R5
   AST_BURST_WRAPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mode == AM_BURST && (&addr)) |=> (addr == '0)) else $error("burst"); // R6
   AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      (held && !s_cs) |=> ($stable(bitcnt) && $stable(phase) && $stable(addr))) else $error("hold"); // R9
   AST_STATUS_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      status[5:1] == 5'b0) else $error("status"); // R7

endmodule

// File: tb/spi_sram_target_test.sv
module spi_sram_target_test;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
   logic so_data, so_oe;

   int tests = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_sram_target #(.ADDR_W(8), .PAGE_W(3), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
      .hold_n(hold_n), .so_data(so_data), .so_oe(so_oe)
   );

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_x(input logic b, output logic r, output logic oe);
      si = b;
      wait_clk(HALF);
      r  = so_data;
      oe = so_oe;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe_and, output logic oe_or);
      oe_and = 1'b1;
      oe_or  = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         logic r, o;
         bit_x(tx[i], r, o);
         rx[i]  = r;
         oe_and = oe_and & o;
         oe_or  = oe_or | o;
      end
   endtask

   task automatic sel();
      cs_n = 1'b0;
      wait_clk(HALF);
   endtask

   task automatic desel();
      wait_clk(HALF);
      cs_n = 1'b1;
      wait_clk(2*HALF);
   endtask

   task automatic do_write(input logic [15:0] a, input logic [31:0] d, input int n);
      logic [7:0] rx;
      logic oa, oo;
      sel();
      xfer(8'h02, rx, oa, oo);
      xfer(a[15:8], rx, oa, oo);
      xfer(a[7:0], rx, oa, oo);
      for (int i = 0; i < n; i++) xfer(d[31-8*i -: 8], rx, oa, oo);
      desel();
   endtask

   task automatic do_read(input logic [15:0] a, input int n, output logic [31:0] d, output logic [3:0] oe_ok, output logic [3:0] oe_any);
      logic [7:0] rx;
      logic oa, oo;
      d = '0; oe_ok = '0; oe_any = '0;
      sel();
      xfer(8'h03, rx, oa, oo);
      xfer(a[15:8], rx, oa, oo);
      xfer(a[7:0], rx, oa, oo);
      for (int i = 0; i < n; i++) begin
         xfer(8'h00, rx, oa, oo);
         d[31-8*i -: 8] = rx;
         oe_ok[3-i]  = oa;
         oe_any[3-i] = oo;
      end
      desel();
   endtask

   task automatic wr_stat(input logic [7:0] v);
      logic [7:0] rx;
      logic oa, oo;
      sel();
      xfer(8'h01, rx, oa, oo);
      xfer(v, rx, oa, oo);
      desel();
   endtask

   task automatic rd_stat(output logic [7:0] v, output logic oe_all);
      logic [7:0] rx;
      logic oo;
      sel();
      xfer(8'h05, rx, oe_all, oo);
      xfer(8'h00, v, oe_all, oo);
      desel();
   endtask

   task automatic read1(input logic [15:0] a, output logic [7:0] v);
      logic [31:0] d;
      logic [3:0] ok, any;
      do_read(a, 1, d, ok, any);
      v = d[31:24];
   endtask

   task automatic t_reset();
      logic [7:0] s;
      logic oa;
      chk("R1", "so_oe after reset", {7'b0, so_oe}, 8'h00);
      cs_n = 1'b0;
      wait_clk(HALF);
      chk("R1", "so_oe selected idle", {7'b0, so_oe}, 8'h00);
      cs_n = 1'b1;
      wait_clk(2*HALF);
      rd_stat(s, oa);
      chk("R7", "default status", s, 8'h00);
      chk("R3", "status read enable", {7'b0, oa}, 8'h01);
   endtask

   task automatic t_presets();
      do_write(16'h00FE, 32'hCD000000, 1);
      do_write(16'h0018, 32'hEE000000, 1);
      do_write(16'h0031, 32'h11000000, 1);
      do_write(16'h0040, 32'h77000000, 1);
      do_write(16'h0051, 32'h96000000, 1);
   endtask

   task automatic t_word();
      logic [31:0] d;
      logic [3:0] ok, any;
      logic [7:0] v;
      do_write(16'hFF12, 32'h5A000000, 1);
      do_read(16'h0012, 2, d, ok, any);
      chk("R2", "upper address bits ignored", d[31:24], 8'h5A);
      chk("R3", "first read byte driven", {7'b0, ok[3]}, 8'h01);
      chk("R4", "no output after one byte", {7'b0, any[2]}, 8'h00);
      do_write(16'h0030, 32'h44550000, 2);
      read1(16'h0031, v);
      chk("R4", "second write byte ignored", v, 8'h11);
      read1(16'h0030, v);
      chk("R2", "word write stored", v, 8'h44);
   endtask

   task automatic t_page();
      logic [31:0] d;
      logic [3:0] ok, any;
      logic [7:0] s, v;
      logic oa;
      wr_stat(8'hBE);
      rd_stat(s, oa);
      chk("R7", "reserved status bits read 0", s, 8'h80);
      do_write(16'h0016, 32'hA0A1A2A3, 4);
      do_read(16'h0017, 4, d, ok, any);
      chk("R5", "page read word 7", d[31:24], 8'hA1);
      chk("R5", "page wrap to word 0", d[23:16], 8'hA2);
      chk("R5", "page word 1", d[15:8], 8'hA3);
      chk("R5", "page word 2", d[7:0], 8'h5A);
      wr_stat(8'h00);
      read1(16'h0018, v);
      chk("R5", "next page untouched", v, 8'hEE);
   endtask

   task automatic t_burst();
      logic [31:0] d;
      logic [3:0] ok, any;
      wr_stat(8'h40);
      do_write(16'h00FF, 32'hB0B1B200, 3);
      do_read(16'h00FE, 4, d, ok, any);
      chk("R6", "burst byte FE", d[31:24], 8'hCD);
      chk("R6", "burst byte FF", d[23:16], 8'hB0);
      chk("R6", "burst wrap to 00", d[15:8], 8'hB1);
      chk("R6", "burst byte 01", d[7:0], 8'hB2);
      chk("R6", "burst enable all bytes", {4'b0, ok}, 8'h0F);
   endtask

   task automatic t_reserved();
      logic [7:0] v, s;
      logic oa;
      wr_stat(8'hC0);
      rd_stat(s, oa);
      chk("R7", "status mode 11 kept", s, 8'hC0);
      do_write(16'h0030, 32'hD0D10000, 2);
      read1(16'h0030, v);
      chk("R4", "reserved mode first byte", v, 8'hD0);
      read1(16'h0031, v);
      chk("R4", "reserved mode acts as word", v, 8'h11);
      wr_stat(8'h00);
   endtask

   task automatic t_abandon();
      logic [7:0] rx, v, s;
      logic oa, oo, r, o;
      sel();
      xfer(8'h02, rx, oa, oo);
      xfer(8'h00, rx, oa, oo);
      xfer(8'h40, rx, oa, oo);
      for (int i = 0; i < 5; i++) bit_x(1'b0, r, o);
      desel();
      read1(16'h0040, v);
      chk("R8", "partial write discarded", v, 8'h77);
      sel();
      xfer(8'h03, rx, oa, oo);
      xfer(8'h00, rx, oa, oo);
      xfer(8'h40, rx, oa, oo);
      for (int i = 0; i < 3; i++) bit_x(1'b0, r, o);
      desel();
      chk("R1", "so_oe low after deselect", {7'b0, so_oe}, 8'h00);
      rd_stat(s, oa);
      chk("R8", "new command after abort", s, 8'h00);
   endtask

   task automatic hold_toggle(input int n);
      for (int i = 0; i < n; i++) begin
         si = ~si;
         wait_clk(HALF);
         sck = 1'b1;
         wait_clk(HALF);
         sck = 1'b0;
      end
   endtask

   task automatic t_hold_low();
      logic [7:0] rx, v;
      logic oa, oo, r, o;
      logic [7:0] tx;
      tx = 8'hC3;
      sel();
      xfer(8'h02, rx, oa, oo);
      xfer(8'h00, rx, oa, oo);
      xfer(8'h50, rx, oa, oo);
      for (int i = 7; i >= 5; i--) bit_x(tx[i], r, o);
      wait_clk(HALF);
      hold_n = 1'b0;
      wait_clk(HALF);
      hold_toggle(3);
      hold_n = 1'b1;
      wait_clk(HALF);
      for (int i = 4; i >= 0; i--) bit_x(tx[i], r, o);
      desel();
      read1(16'h0050, v);
      chk("R9", "write resumes at same bit", v, 8'hC3);

      sel();
      xfer(8'h03, rx, oa, oo);
      xfer(8'h00, rx, oa, oo);
      xfer(8'h51, rx, oa, oo);
      for (int i = 7; i >= 4; i--) begin bit_x(1'b0, r, o); v[i] = r; end
      wait_clk(HALF);
      hold_n = 1'b0;
      wait_clk(HALF);
      chk("R9", "so_oe off during pause", {7'b0, so_oe}, 8'h00);
      hold_toggle(3);
      hold_n = 1'b1;
      wait_clk(HALF);
      for (int i = 3; i >= 0; i--) begin bit_x(1'b0, r, o); v[i] = r; end
      desel();
      chk("R9", "read resumes at same bit", v, 8'h96);
   endtask

   task automatic t_hold_high();
      logic [7:0] rx, v, tx;
      logic oa, oo, r, o;
      tx = 8'hA5;
      sel();
      xfer(8'h02, rx, oa, oo);
      xfer(8'h00, rx, oa, oo);
      xfer(8'h52, rx, oa, oo);
      for (int i = 7; i >= 4; i--) bit_x(tx[i], r, o);
      si = tx[3];
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF/2);
      hold_n = 1'b0;
      wait_clk(HALF/2);
      sck = 1'b0;
      wait_clk(HALF);
      chk("R10", "so_oe off after pending pause", {7'b0, so_oe}, 8'h00);
      hold_toggle(2);
      hold_n = 1'b1;
      wait_clk(HALF);
      for (int i = 2; i >= 0; i--) bit_x(tx[i], r, o);
      desel();
      read1(16'h0052, v);
      chk("R10", "pause after falling edge", v, 8'hA5);
   endtask

   task automatic t_hold_off();
      logic [7:0] v, s;
      logic oa;
      wr_stat(8'h01);
      hold_n = 1'b0;
      do_write(16'h0053, 32'h3C000000, 1);
      read1(16'h0053, v);
      chk("R11", "transfer with hold_n low", v, 8'h3C);
      rd_stat(s, oa);
      chk("R11", "status read with hold_n low", s, 8'h01);
      chk("R11", "so_oe ignores hold_n", {7'b0, oa}, 8'h01);
      hold_n = 1'b1;
      wr_stat(8'h00);
   endtask

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      t_reset();
      t_presets();
      t_word();
      t_page();
      t_burst();
      t_reserved();
      t_abandon();
      t_hold_low();
      t_hold_high();
      t_hold_off();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule